// File: doc/BRIEF.md
# Byte ALU with Banked Operands

This block is the execute stage of a small accumulator machine with 8-bit data. Each cycle it can take one operation: a working register (W), a byte from data memory, an 8-bit literal and the carry flag come in. The block then writes one result to a single destination. The data memory is a plain array inside the block, addressed with 12 bits. The operand address comes from an 8-bit offset `f`. When the bank-select input is low, the offset selects a fixed window made of the bottom and top of the memory. When it is high, the current bank number is placed above the offset.

The block supports these operations:
- rotates, either through carry or wrapping within the byte;
- subtract with borrow, in both operand orders;
- nibble swap;
- XOR with the memory byte or with a literal;
- unsigned 8x8 multiply, with the 16-bit product kept in its own register pair.

A few support operations load and store W and load the bank number. The destination bit picks whether a result goes to W or back to the memory byte. Registered write strobes and the last memory write address and data are visible at the ports.

Top module: `byte_exec_unit`

## Requirements
- R1: After reset, W, bank number, all flags (C, Z, N, OV), product, write strobes, last write address and last write data read zero.
- R2: With the bank-select input at 0, offsets 0x00..0x7F address 0x000..0x07F and offsets 0x80..0xFF address 0xF80..0xFFF, whatever the bank number is.
- R3: With the bank-select input at 1, the address is {bank[3:0], f}. Opcode 2 loads the bank number from literal bits [3:0] and pulses the bank strobe.
- R4: For opcodes 4..12, destination bit 0 writes the result to W and destination bit 1 writes it to the addressed memory byte. Every accepted opcode other than 0 raises exactly one of the four strobes (W, memory, product, bank) in the next cycle. A memory write reports its address and data.
- R5: Opcode 5 rotates left through carry: result {f[6:0],C}, new C = f[7]. Opcode 7 rotates right through carry: result {C,f[7:1]}, new C = f[0]. Both update Z and N.
- R6: Opcode 6 rotates left within the byte and opcode 8 rotates right within the byte. Both leave C unchanged and update Z and N.
- R7: Opcode 9 computes W - f - (1-C) in two's complement. C is set when no borrow occurs. Z, N and signed overflow OV follow the 8-bit result.
- R8: Opcode 10 computes f - W - (1-C), with the same flag rules as R7.
- R9: Opcode 11 exchanges the two nibbles of the memory byte and changes no flag.
- R10: Opcode 12 XORs W with the memory byte and opcode 13 XORs W with the literal. Both update Z and N; the literal form always writes W.
- R11: Opcode 14 multiplies W by the literal and opcode 15 multiplies W by the memory byte, both unsigned. The 16-bit product goes to the product pair with the high byte on top. W, the memory byte and all flags are unchanged.
- R12: Opcode 1 loads the literal into W. Opcode 3 stores W to the addressed byte. Opcode 4 moves the memory byte to the destination and updates Z and N. Opcode 0 does nothing.
- R13: While the valid input is low, no register, strobe or memory byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode |
| f_i | input | 8 | Memory offset |
| k_i | input | 8 | Literal |
| dest_f_i | input | 1 | 1: result to memory byte, 0: result to W |
| use_bank_i | input | 1 | 1: bank number forms the upper address, 0: fixed window |
| w_o | output | 8 | Working register |
| bank_o | output | 4 | Bank number |
| c_o | output | 1 | Carry flag (1 = no borrow) |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| ov_o | output | 1 | Signed overflow flag |
| prod_o | output | 16 | Product pair, high byte in [15:8] |
| wr_w_o | output | 1 | W was written last cycle |
| wr_f_o | output | 1 | Memory was written last cycle |
| wr_p_o | output | 1 | Product was written last cycle |
| wr_b_o | output | 1 | Bank number was written last cycle |
| wr_addr_o | output | 12 | Address of the last memory write |
| wr_data_o | output | 8 | Data of the last memory write |

## Verification
The hardest state to reach is a subtract that starts from a known carry. The carry can only be set or cleared as a side effect of other operations, so the bench first sets it: it stores 0x80 or 0x00 to a scratch byte and rotates that byte left through carry. This reaches both borrow-in values. With carry prepared this way, the bench drives subtractions that produce signed overflow and a zero result. Bank aliasing is covered by storing different values through the fixed window and through bank 5 at the same offset, then reading each back through its own path.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
    localparam int BYTE_W = 8;
    localparam int PROD_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_LD_LIT   = 4'd1,
        OP_SET_BANK = 4'd2,
        OP_ST_W     = 4'd3,
        OP_LD_F     = 4'd4,
        OP_ROLC     = 4'd5,
        OP_ROLN     = 4'd6,
        OP_RORC     = 4'd7,
        OP_RORN     = 4'd8,
        OP_SUB_WF   = 4'd9,
        OP_SUB_FW   = 4'd10,
        OP_SWAP     = 4'd11,
        OP_XOR_F    = 4'd12,
        OP_XOR_K    = 4'd13,
        OP_MUL_K    = 4'd14,
        OP_MUL_F    = 4'd15
    } bxu_op_e;
endpackage

// File: rtl/bxu_addr_gen.sv
module bxu_addr_gen #(
    parameter int          BANK_W    = 4,
    parameter int          BYTE_W    = 8,
    parameter logic [7:0]  ACC_SPLIT = 8'h80
) (
    input  logic                      use_bank_i,
    input  logic [BANK_W-1:0]         bank_i,
    input  logic [BYTE_W-1:0]         f_i,
    output logic [BANK_W+BYTE_W-1:0]  addr_o
);
    localparam int ADDR_W = BANK_W + BYTE_W;

    logic [ADDR_W-1:0] win_addr;
    logic [ADDR_W-1:0] bank_addr;

    // Fixed window: low offsets map to the bottom page, high ones to the top page
    always_comb begin
        if (f_i < BYTE_W'(ACC_SPLIT)) begin
            win_addr = {{BANK_W{1'b0}}, f_i};
        end else begin
            win_addr = {{BANK_W{1'b1}}, f_i};
        end
        bank_addr = {bank_i, f_i};
        addr_o    = use_bank_i ? bank_addr : win_addr;
    end
endmodule

// File: rtl/bxu_alu.sv
module bxu_alu
    import bxu_pkg::*;
(
    input  bxu_op_e               op_i,
    input  logic [BYTE_W-1:0]     w_i,
    input  logic [BYTE_W-1:0]     f_i,
    input  logic [BYTE_W-1:0]     k_i,
    input  logic                  c_i,
    output logic [BYTE_W-1:0]     res_o,
    output logic [PROD_W-1:0]     prod_o,
    output logic                  c_o,
    output logic                  ov_o,
    output logic                  set_c_o,
    output logic                  set_zn_o,
    output logic                  set_ov_o
);
    logic [BYTE_W-1:0] sub_a;
    logic [BYTE_W-1:0] sub_b;
    logic [BYTE_W-1:0] sub_nb;
    logic [BYTE_W:0]   sub_sum;
    logic [BYTE_W-1:0] mul_b;

    // Shared subtractor: a + ~b + C, carry out means no borrow
    always_comb begin
        if (op_i == OP_SUB_FW) begin
            sub_a = f_i;
            sub_b = w_i;
        end else begin
            sub_a = w_i;
            sub_b = f_i;
        end
        sub_nb  = ~sub_b;
        sub_sum = {1'b0, sub_a} + {1'b0, sub_nb} + {{BYTE_W{1'b0}}, c_i};
        mul_b   = (op_i == OP_MUL_K) ? k_i : f_i;
        prod_o  = PROD_W'(w_i) * PROD_W'(mul_b);
    end

    always_comb begin
        res_o    = '0;
        c_o      = c_i;
        ov_o     = 1'b0;
        set_c_o  = 1'b0;
        set_zn_o = 1'b0;
        set_ov_o = 1'b0;
        unique case (op_i)
            OP_NOP:      res_o = '0;
            OP_LD_LIT,
            OP_SET_BANK: res_o = k_i;
            OP_ST_W:     res_o = w_i;
            OP_LD_F: begin
                res_o    = f_i;
                set_zn_o = 1'b1;
            end
            OP_ROLC: begin
                res_o    = {f_i[BYTE_W-2:0], c_i};
                c_o      = f_i[BYTE_W-1];
                set_c_o  = 1'b1;
                set_zn_o = 1'b1;
            end
            OP_RORC: begin
                res_o    = {c_i, f_i[BYTE_W-1:1]};
                c_o      = f_i[0];
                set_c_o  = 1'b1;
                set_zn_o = 1'b1;
            end
            OP_ROLN: begin
                res_o    = {f_i[BYTE_W-2:0], f_i[BYTE_W-1]};
                set_zn_o = 1'b1;
            end
            OP_RORN: begin
                res_o    = {f_i[0], f_i[BYTE_W-1:1]};
                set_zn_o = 1'b1;
            end
            OP_SUB_WF,
            OP_SUB_FW: begin
                res_o    = sub_sum[BYTE_W-1:0];
                c_o      = sub_sum[BYTE_W];
                ov_o     = (sub_a[BYTE_W-1] != sub_b[BYTE_W-1]) &&
                           (sub_sum[BYTE_W-1] != sub_a[BYTE_W-1]);
                set_c_o  = 1'b1;
                set_zn_o = 1'b1;
                set_ov_o = 1'b1;
            end
            OP_SWAP:     res_o = {f_i[BYTE_W/2-1:0], f_i[BYTE_W-1:BYTE_W/2]};
            OP_XOR_F: begin
                res_o    = w_i ^ f_i;
                set_zn_o = 1'b1;
            end
            OP_XOR_K: begin
                res_o    = w_i ^ k_i;
                set_zn_o = 1'b1;
            end
            OP_MUL_K,
            OP_MUL_F:    res_o = w_i;
            default:     res_o = '0;
        endcase
    end
endmodule

// File: rtl/bxu_dest_dec.sv
module bxu_dest_dec
    import bxu_pkg::*;
(
    input  logic    valid_i,
    input  bxu_op_e op_i,
    input  logic    dest_f_i,
    output logic    we_w_o,
    output logic    we_f_o,
    output logic    we_p_o,
    output logic    we_b_o
);
    always_comb begin
        we_w_o = 1'b0;
        we_f_o = 1'b0;
        we_p_o = 1'b0;
        we_b_o = 1'b0;
        if (valid_i) begin
            unique case (op_i)
                OP_NOP:              ;
                OP_LD_LIT, OP_XOR_K: we_w_o = 1'b1;
                OP_ST_W:             we_f_o = 1'b1;
                OP_SET_BANK:         we_b_o = 1'b1;
                OP_MUL_K, OP_MUL_F:  we_p_o = 1'b1;
                default: begin
                    we_f_o = dest_f_i;
                    we_w_o = !dest_f_i;
                end
            endcase
        end
    end
endmodule

// File: rtl/byte_exec_unit.sv
module byte_exec_unit
    import bxu_pkg::*;
#(
    parameter int         BANK_W    = 4,
    parameter logic [7:0] ACC_SPLIT = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid_i,
    input  logic [3:0]               op_i,
    input  logic [7:0]               f_i,
    input  logic [7:0]               k_i,
    input  logic                     dest_f_i,
    input  logic                     use_bank_i,
    output logic [7:0]               w_o,
    output logic [BANK_W-1:0]        bank_o,
    output logic                     c_o,
    output logic                     z_o,
    output logic                     n_o,
    output logic                     ov_o,
    output logic [15:0]              prod_o,
    output logic                     wr_w_o,
    output logic                     wr_f_o,
    output logic                     wr_p_o,
    output logic                     wr_b_o,
    output logic [BANK_W+7:0]        wr_addr_o,
    output logic [7:0]               wr_data_o
);
    localparam int ADDR_W    = BANK_W + BYTE_W;
    localparam int MEM_DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [BYTE_W-1:0] w;
        logic [BANK_W-1:0] bank;
        logic              c;
        logic              z;
        logic              n;
        logic              ov;
        logic [PROD_W-1:0] prod;
        logic              wr_w;
        logic              wr_f;
        logic              wr_p;
        logic              wr_b;
        logic [ADDR_W-1:0] wr_addr;
        logic [BYTE_W-1:0] wr_data;
    } exu_state_t;

    exu_state_t st_d, st_q;

    bxu_op_e           op;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] f_val;
    logic [BYTE_W-1:0] alu_res;
    logic [PROD_W-1:0] alu_prod;
    logic              alu_c, alu_ov, set_c, set_zn, set_ov;
    logic              we_w, we_f, we_p, we_b;
    logic [BYTE_W-1:0] mem_q [MEM_DEPTH];

    assign op = bxu_op_e'(op_i);

    bxu_addr_gen #(
        .BANK_W   (BANK_W),
        .BYTE_W   (BYTE_W),
        .ACC_SPLIT(ACC_SPLIT)
    ) u_addr (
        .use_bank_i(use_bank_i),
        .bank_i    (st_q.bank),
        .f_i       (f_i),
        .addr_o    (addr)
    );

    assign f_val = mem_q[addr];

    bxu_alu u_alu (
        .op_i    (op),
        .w_i     (st_q.w),
        .f_i     (f_val),
        .k_i     (k_i),
        .c_i     (st_q.c),
        .res_o   (alu_res),
        .prod_o  (alu_prod),
        .c_o     (alu_c),
        .ov_o    (alu_ov),
        .set_c_o (set_c),
        .set_zn_o(set_zn),
        .set_ov_o(set_ov)
    );

    bxu_dest_dec u_dest (
        .valid_i (op_valid_i),
        .op_i    (op),
        .dest_f_i(dest_f_i),
        .we_w_o  (we_w),
        .we_f_o  (we_f),
        .we_p_o  (we_p),
        .we_b_o  (we_b)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wr_w = we_w;
        st_d.wr_f = we_f;
        st_d.wr_p = we_p;
        st_d.wr_b = we_b;
        if (we_w) st_d.w    = alu_res;
        if (we_b) st_d.bank = alu_res[BANK_W-1:0];
        if (we_p) st_d.prod = alu_prod;
        if (we_f) begin
            st_d.wr_addr = addr;
            st_d.wr_data = alu_res;
        end
        if (op_valid_i) begin
            if (set_c)  st_d.c  = alu_c;
            if (set_ov) st_d.ov = alu_ov;
            if (set_zn) begin
                st_d.z = (alu_res == '0);
                st_d.n = alu_res[BYTE_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we_f) begin
            mem_q[addr] <= alu_res;
        end
    end

    assign w_o       = st_q.w;
    assign bank_o    = st_q.bank;
    assign c_o       = st_q.c;
    assign z_o       = st_q.z;
    assign n_o       = st_q.n;
    assign ov_o      = st_q.ov;
    assign prod_o    = st_q.prod;
    assign wr_w_o    = st_q.wr_w;
    assign wr_f_o    = st_q.wr_f;
    assign wr_p_o    = st_q.wr_p;
    assign wr_b_o    = st_q.wr_b;
    assign wr_addr_o = st_q.wr_addr;
    assign wr_data_o = st_q.wr_data;

    AST_WINDOW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_bank_i && !f_i[7]) |-> (addr[ADDR_W-1:BYTE_W] == '0)); // R2

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i != 4'd0) |=>
            ($countones({st_q.wr_w, st_q.wr_f, st_q.wr_p, st_q.wr_b}) == 1)); // R4

    AST_ROT_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (op_i == 4'd6 || op_i == 4'd8)) |=> $stable(st_q.c)); // R6

    AST_MUL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && (op_i == 4'd14 || op_i == 4'd15)) |=>
            ($stable(st_q.w) && $stable(st_q.c) && $stable(st_q.z) &&
             $stable(st_q.n) && $stable(st_q.ov))); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> ($stable(st_q.w) && $stable(st_q.bank) &&
                         $stable(st_q.prod) && !st_q.wr_f)); // R13
endmodule

// File: tb/sim_byte_exec_unit.sv
`timescale 1ns/1ps
module sim_byte_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [7:0]  f_i = 8'd0;
    logic [7:0]  k_i = 8'd0;
    logic        dest_f_i = 1'b0;
    logic        use_bank_i = 1'b0;
    logic [7:0]  w_o;
    logic [3:0]  bank_o;
    logic        c_o, z_o, n_o, ov_o;
    logic [15:0] prod_o;
    logic        wr_w_o, wr_f_o, wr_p_o, wr_b_o;
    logic [11:0] wr_addr_o;
    logic [7:0]  wr_data_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    byte_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .f_i(f_i), .k_i(k_i), .dest_f_i(dest_f_i), .use_bank_i(use_bank_i),
        .w_o(w_o), .bank_o(bank_o), .c_o(c_o), .z_o(z_o), .n_o(n_o), .ov_o(ov_o),
        .prod_o(prod_o), .wr_w_o(wr_w_o), .wr_f_o(wr_f_o), .wr_p_o(wr_p_o),
        .wr_b_o(wr_b_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    // {req, op, d, a, f, k, expected W, expected C}
    localparam int NVEC = 17;
    localparam logic [34:0] VEC [NVEC] = '{
        {4'd12, 4'd1,  1'b0, 1'b0, 8'h00, 8'h3C, 8'h3C, 1'b0}, // R12 load literal
        {4'd12, 4'd3,  1'b0, 1'b0, 8'h10, 8'h00, 8'h3C, 1'b0}, // R12 store W
        {4'd5,  4'd5,  1'b0, 1'b0, 8'h10, 8'h00, 8'h78, 1'b0}, // R5 rotate left via C
        {4'd12, 4'd1,  1'b0, 1'b0, 8'h00, 8'h81, 8'h81, 1'b0}, // R12
        {4'd12, 4'd3,  1'b0, 1'b0, 8'h20, 8'h00, 8'h81, 1'b0}, // R12
        {4'd5,  4'd5,  1'b0, 1'b0, 8'h20, 8'h00, 8'h02, 1'b1}, // R5 bit 7 into C
        {4'd5,  4'd7,  1'b0, 1'b0, 8'h20, 8'h00, 8'hC0, 1'b1}, // R5 rotate right via C
        {4'd6,  4'd6,  1'b0, 1'b0, 8'h20, 8'h00, 8'h03, 1'b1}, // R6 wrap left
        {4'd6,  4'd8,  1'b0, 1'b0, 8'h20, 8'h00, 8'hC0, 1'b1}, // R6 wrap right
        {4'd9,  4'd11, 1'b0, 1'b0, 8'h10, 8'h00, 8'hC3, 1'b1}, // R9 swap
        {4'd10, 4'd13, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h3C, 1'b1}, // R10 xor literal
        {4'd10, 4'd12, 1'b0, 1'b0, 8'h20, 8'h00, 8'hBD, 1'b1}, // R10 xor byte
        {4'd12, 4'd1,  1'b0, 1'b0, 8'h00, 8'h50, 8'h50, 1'b1}, // R12
        {4'd7,  4'd9,  1'b0, 1'b0, 8'h10, 8'h00, 8'h14, 1'b1}, // R7 no borrow
        {4'd8,  4'd10, 1'b0, 1'b0, 8'h10, 8'h00, 8'h28, 1'b1}, // R8 reverse order
        {4'd7,  4'd9,  1'b0, 1'b0, 8'h10, 8'h00, 8'hEC, 1'b0}, // R7 borrow out
        {4'd7,  4'd9,  1'b0, 1'b0, 8'h10, 8'h00, 8'hAF, 1'b1}  // R7 borrow in
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic d, input logic a,
                         input logic [7:0] f, input logic [7:0] k);
        @(negedge clk);
        op_i = op; dest_f_i = d; use_bank_i = a; f_i = f; k_i = k;
        op_valid_i = 1'b1;
        @(negedge clk);
        op_valid_i = 1'b0;
    endtask

    task automatic set_carry(input logic b);
        do_op(4'd1, 1'b0, 1'b0, 8'h00, b ? 8'h80 : 8'h00);
        do_op(4'd3, 1'b0, 1'b0, 8'h7F, 8'h00);
        do_op(4'd5, 1'b0, 1'b0, 8'h7F, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] sv_flags;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 w", {8'h0, w_o}, 16'h0);
        check("R1 bank/flags", {8'h0, bank_o, c_o, z_o, n_o, ov_o}, 16'h0);
        check("R1 prod", prod_o, 16'h0);
        check("R1 strobes/addr", {wr_w_o, wr_f_o, wr_p_o, wr_b_o, wr_addr_o}, 16'h0);
        check("R1 wdata", {8'h0, wr_data_o}, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [34:0] v;
            v = VEC[i];
            do_op(v[30:27], v[26], v[25], v[24:17], v[16:9]);
            check($sformatf("R%0d vec%0d W", v[34:31], i), {8'h0, w_o}, {8'h0, v[8:1]});
            check($sformatf("R%0d vec%0d C", v[34:31], i), {15'h0, c_o}, {15'h0, v[0]});
        end

        // R13 idle cycle with a load presented
        @(negedge clk);
        op_i = 4'd1; k_i = 8'h77; op_valid_i = 1'b0;
        @(negedge clk);
        check("R13 W held", {8'h0, w_o}, 16'h00AF);
        check("R13 no strobe", {12'h0, wr_w_o, wr_f_o, wr_p_o, wr_b_o}, 16'h0);

        // R3 bank load
        do_op(4'd2, 1'b0, 1'b0, 8'h00, 8'h05);
        check("R3 bank", {12'h0, bank_o}, 16'h5);
        check("R4 bank strobe", {12'h0, wr_w_o, wr_f_o, wr_p_o, wr_b_o}, 16'h1);
        // R2 window ignores bank
        do_op(4'd1, 1'b0, 1'b0, 8'h00, 8'hA5);
        do_op(4'd3, 1'b0, 1'b0, 8'h90, 8'h00);
        check("R2 high window", {4'h0, wr_addr_o}, 16'h0F90);
        check("R4 store strobe", {12'h0, wr_w_o, wr_f_o, wr_p_o, wr_b_o}, 16'h4);
        do_op(4'd3, 1'b0, 1'b0, 8'h12, 8'h00);
        check("R2 low window", {4'h0, wr_addr_o}, 16'h0012);
        do_op(4'd1, 1'b0, 1'b0, 8'h00, 8'h5A);
        do_op(4'd3, 1'b0, 1'b1, 8'h90, 8'h00);
        check("R3 banked addr", {4'h0, wr_addr_o}, 16'h0590);
        do_op(4'd4, 1'b0, 1'b0, 8'h90, 8'h00);
        check("R2 read window", {8'h0, w_o}, 16'h00A5);
        do_op(4'd4, 1'b0, 1'b1, 8'h90, 8'h00);
        check("R3 read bank", {8'h0, w_o}, 16'h005A);

        // R4 result to memory
        do_op(4'd6, 1'b1, 1'b1, 8'h90, 8'h00);
        check("R4 W untouched", {8'h0, w_o}, 16'h005A);
        check("R4 mem strobe", {12'h0, wr_w_o, wr_f_o, wr_p_o, wr_b_o}, 16'h4);
        check("R4 wdata", {8'h0, wr_data_o}, 16'h00B4);
        do_op(4'd4, 1'b0, 1'b1, 8'h90, 8'h00);
        check("R4 readback", {8'h0, w_o}, 16'h00B4);

        // R11 multiply
        do_op(4'd1, 1'b0, 1'b0, 8'h00, 8'hFF);
        sv_flags = {c_o, z_o, n_o, ov_o};
        do_op(4'd14, 1'b0, 1'b0, 8'h00, 8'hFF);
        check("R11 prod lit", prod_o, 16'hFE01);
        check("R11 W kept", {8'h0, w_o}, 16'h00FF);
        check("R11 flags kept", {12'h0, c_o, z_o, n_o, ov_o}, {12'h0, sv_flags});
        check("R11 prod strobe", {12'h0, wr_w_o, wr_f_o, wr_p_o, wr_b_o}, 16'h2);
        do_op(4'd15, 1'b0, 1'b0, 8'h10, 8'h00);
        check("R11 prod byte", prod_o, 16'h3BC4);
        do_op(4'd4, 1'b0, 1'b0, 8'h10, 8'h00);
        check("R11 byte kept", {8'h0, w_o}, 16'h003C);

        // R7 signed overflow
        set_carry(1'b1);
        do_op(4'd1, 1'b0, 1'b0, 8'h00, 8'h01);
        do_op(4'd3, 1'b0, 1'b0, 8'h30, 8'h00);
        do_op(4'd1, 1'b0, 1'b0, 8'h00, 8'h80);
        do_op(4'd9, 1'b0, 1'b0, 8'h30, 8'h00);
        check("R7 ovf result", {8'h0, w_o}, 16'h007F);
        check("R7 ovf flags", {12'h0, c_o, z_o, n_o, ov_o}, 16'h9);

        // R8 zero result
        set_carry(1'b1);
        do_op(4'd1, 1'b0, 1'b0, 8'h00, 8'h01);
        do_op(4'd10, 1'b0, 1'b0, 8'h30, 8'h00);
        check("R8 zero result", {8'h0, w_o}, 16'h0000);
        check("R8 zero flags", {12'h0, c_o, z_o, n_o, ov_o}, 16'hC);

        // R10 zero from xor
        do_op(4'd1, 1'b0, 1'b0, 8'h00, 8'h3C);
        do_op(4'd13, 1'b0, 1'b0, 8'h00, 8'h3C);
        check("R10 xor zero", {8'h0, w_o, 4'h0, z_o, n_o, 2'b0}, 16'h0008);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule